// File: doc/BRIEF.md
# Translation Cache with Global Entries

This block keeps a small fully associative set of recent page translations in front of a page walker. The processor side presents a 32-bit virtual address. When one of the cached entries carries that address's 20-bit page number, the block returns the 32-bit physical address in the same cycle. That address is the cached 20-bit frame with the untouched 12-bit page offset appended. When no entry matches, the block reports a miss, and the surrounding logic starts a walk. The walker then installs its result through the fill port. Each fill carries the frame and two flags: a global flag and a writable flag.

A write to the directory base register pulses `base_wr`. This drops every translation that belongs to the old address space and keeps the entries marked global. A single-page invalidate input removes one page number whatever its flags. Different page numbers may point at the same frame, and each such alias occupies its own entry. A page number never occupies two entries, because a fill for a page number that is already cached rewrites that entry in place. New entries go to the lowest-numbered free slot. When every slot is in use, a round-robin pointer picks the slot to evict.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses.
- R2: A lookup is combinational. On a hit, `lk_hit` is 1, `lk_paddr` is {cached frame, `lk_vaddr[11:0]`} and `lk_wr` is the entry's writable flag, all in the cycle the address is presented.
- R3: On a miss, `lk_hit`, `lk_paddr` and `lk_wr` are all zero.
- R4: A fill is visible to lookups after the next rising clock edge. A fill whose page number matches a valid entry rewrites that entry and uses no other slot.
- R5: Two different page numbers may hold the same frame, and both return it.
- R6: A new page number goes to the lowest-indexed invalid entry. When no entry is invalid, it replaces the entry named by a round-robin pointer. The pointer is 0 after reset and advances by one, with wraparound, on each such eviction.
- R7: A `base_wr` pulse invalidates every entry whose global flag is 0 at the next edge and leaves global entries intact.
- R8: `inv_en` invalidates the entry whose page number equals `inv_vpn` at the next edge, whether or not it is global.
- R9: When a fill coincides with `base_wr` or `inv_en`, the clearing is applied first and the filled entry survives. A slot freed by that clearing counts as free for placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 32 | Physical address (zero on miss) |
| lk_wr | output | 1 | Writable flag of the hit entry |
| fill_en | input | 1 | Install a walker result |
| fill_vpn | input | 20 | Page number being installed |
| fill_pfn | input | 20 | Frame being installed |
| fill_glb | input | 1 | Global flag of the new entry |
| fill_wr | input | 1 | Writable flag of the new entry |
| base_wr | input | 1 | Address-space switch: drop non-global entries |
| inv_en | input | 1 | Invalidate one page number |
| inv_vpn | input | 20 | Page number to invalidate |

## Verification
Any wrong internal state reaches the ports on the next lookup of the affected page. A lost valid bit appears as a miss, a stale entry as a hit with an old frame, and a corrupted frame or flag as a wrong `lk_paddr` or `lk_wr` in that same cycle. A wrong victim choice or a pointer that does not advance stays hidden until the cache is full and another page is installed. The bench therefore fills to capacity, evicts, and probes every resident page. A duplicate tag left by a faulty rewrite surfaces one eviction later, when the wrong page disappears.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VPN_W = 20;
    localparam int PFN_W = 20;
    localparam int OFF_W = 12;
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PFN_W + OFF_W;

    typedef struct packed {
        logic             v;
        logic             g;
        logic             w;
        logic [VPN_W-1:0] tag;
        logic [PFN_W-1:0] pfn;
    } xlat_ent_t;
endpackage

// File: rtl/xlat_cam.sv
// Parallel tag compare across all entries.
module xlat_cam #(
    parameter int N = 8,
    parameter int W = 20
) (
    input  logic [N-1:0]   vld,
    input  logic [N*W-1:0] tags,
    input  logic [W-1:0]   key,
    output logic [N-1:0]   match
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = vld[i] && (tags[i*W +: W] == key);
    end
endmodule

// File: rtl/xlat_pick.sv
// Lowest-index set bit finder.
module xlat_pick #(
    parameter int N = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_wr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_glb,
    input  logic             fill_wr,
    input  logic             base_wr,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        xlat_ent_t [ENTRIES-1:0] ent;
        logic [PTR_W-1:0]        rr;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0]       vld_vec, glb_vec, live;
    logic [ENTRIES*VPN_W-1:0] tag_flat;
    logic [ENTRIES-1:0]       lk_match, iv_match, fl_match;
    logic                     fl_any, free_any;
    logic [PTR_W-1:0]         fl_idx, free_idx;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            vld_vec[i]               = st_q.ent[i].v;
            glb_vec[i]               = st_q.ent[i].g;
            tag_flat[i*VPN_W +: VPN_W] = st_q.ent[i].tag;
        end
    end

    // entries surviving this cycle's flush and invalidate
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            live[i] = vld_vec[i]
                      && !(base_wr && !glb_vec[i])
                      && !(inv_en && iv_match[i]);
        end
    end

    xlat_cam #(.N(ENTRIES), .W(VPN_W)) u_lk_cam (
        .vld(vld_vec), .tags(tag_flat), .key(lk_vaddr[VA_W-1:OFF_W]), .match(lk_match));

    xlat_cam #(.N(ENTRIES), .W(VPN_W)) u_iv_cam (
        .vld(vld_vec), .tags(tag_flat), .key(inv_vpn), .match(iv_match));

    xlat_cam #(.N(ENTRIES), .W(VPN_W)) u_fl_cam (
        .vld(live), .tags(tag_flat), .key(fill_vpn), .match(fl_match));

    xlat_pick #(.N(ENTRIES), .IW(PTR_W)) u_fl_pick (
        .req(fl_match), .any(fl_any), .idx(fl_idx));

    xlat_pick #(.N(ENTRIES), .IW(PTR_W)) u_free_pick (
        .req(~live), .any(free_any), .idx(free_idx));

    // lookup read-out
    always_comb begin
        logic [PFN_W-1:0] pfn_sel;
        logic             w_sel;
        pfn_sel = '0;
        w_sel   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                pfn_sel = pfn_sel | st_q.ent[i].pfn;
                w_sel   = w_sel | st_q.ent[i].w;
            end
        end
        lk_hit   = |lk_match;
        lk_wr    = w_sel;
        lk_paddr = lk_hit ? {pfn_sel, lk_vaddr[OFF_W-1:0]} : '0;
    end

    // next state
    always_comb begin
        logic [PTR_W-1:0] slot;
        st_d = st_q;
        slot = st_q.rr;
        for (int i = 0; i < ENTRIES; i++) begin
            st_d.ent[i].v = live[i];
        end
        if (fill_en) begin
            if (fl_any) begin
                slot = fl_idx;
            end else if (free_any) begin
                slot = free_idx;
            end else begin
                slot    = st_q.rr;
                st_d.rr = (st_q.rr == LAST) ? '0 : st_q.rr + 1'b1;
            end
            st_d.ent[slot] = '{v: 1'b1, g: fill_glb, w: fill_wr,
                               tag: fill_vpn, pfn: fill_pfn};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               lk_hit,
    input logic [PA_W-1:0]    lk_paddr,
    input logic               lk_wr,
    input logic               fill_en,
    input logic [VPN_W-1:0]   fill_vpn,
    input logic [PFN_W-1:0]   fill_pfn,
    input logic               base_wr,
    input logic               inv_en,
    input logic [VPN_W-1:0]   inv_vpn,
    input logic [ENTRIES-1:0] vld_vec,
    input logic [ENTRIES-1:0] glb_vec
);
    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0 && !lk_wr));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    // R4
    fill_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (lk_vaddr[VA_W-1:OFF_W] != $past(fill_vpn)
                     || (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_pfn))));

    // R7
    flush_keep_glb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && !fill_en) |=> ((vld_vec & ~glb_vec) == '0));

    // R8
    inv_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !fill_en) |=>
            !(lk_hit && lk_vaddr[VA_W-1:OFF_W] == $past(inv_vpn)));

    // R6
    fill_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !base_wr && !inv_en) |=>
            ($countones(vld_vec) >= $past($countones(vld_vec))));
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .lk_wr(lk_wr), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .base_wr(base_wr),
    .inv_en(inv_en), .inv_vpn(inv_vpn), .vld_vec(vld_vec), .glb_vec(glb_vec));

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_wr;
    logic [31:0] lk_paddr;
    logic        fill_en = 1'b0, fill_glb = 1'b0, fill_wr = 1'b0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0, inv_vpn = '0;
    logic        base_wr = 1'b0, inv_en = 1'b0;
    int          total = 0, bad = 0;

    always #4 clk = ~clk;

    xlat_cache u_xlat_cache (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
        .lk_paddr(lk_paddr), .lk_wr(lk_wr), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_glb(fill_glb),
        .fill_wr(fill_wr), .base_wr(base_wr), .inv_en(inv_en), .inv_vpn(inv_vpn));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // drive at a falling edge; the rising edge in between installs it
    task automatic fill(logic [19:0] vpn, logic [19:0] pfn, logic g, logic w);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_glb = g; fill_wr = w;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic look(string req, logic [31:0] va, logic hit, logic [31:0] pa, logic w);
        lk_vaddr = va;
        #1;
        check(req, {31'd0, lk_hit}, {31'd0, hit});
        check(req, lk_paddr, pa);
        check(req, {31'd0, lk_wr}, {31'd0, w});
    endtask

    task automatic t_reset();
        do_reset();
        look("R1", 32'h1234_5678, 1'b0, 32'h0, 1'b0);
        look("R3", 32'h0000_0000, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_hit();
        do_reset();
        fill(20'h12345, 20'hABCDE, 1'b0, 1'b1);
        look("R2", 32'h1234_5678, 1'b1, 32'hABCD_E678, 1'b1);
        look("R2", 32'h1234_5FFF, 1'b1, 32'hABCD_EFFF, 1'b1);
        look("R3", 32'h1234_6000, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_fill_timing();
        do_reset();
        @(negedge clk);
        lk_vaddr = 32'h0005_5010;
        fill_en = 1'b1; fill_vpn = 20'h00055; fill_pfn = 20'h0F00F; fill_glb = 1'b0; fill_wr = 1'b0;
        #1;
        check("R4 before edge", {31'd0, lk_hit}, 32'd0);
        @(negedge clk);
        fill_en = 1'b0;
        look("R4 after edge", 32'h0005_5010, 1'b1, 32'h0F00_F010, 1'b0);
    endtask

    task automatic t_alias();
        do_reset();
        fill(20'h00001, 20'h77777, 1'b0, 1'b0);
        fill(20'h00002, 20'h77777, 1'b0, 1'b1);
        look("R5", 32'h0000_1ABC, 1'b1, 32'h7777_7ABC, 1'b0);
        look("R5", 32'h0000_2ABC, 1'b1, 32'h7777_7ABC, 1'b1);
    endtask

    task automatic t_replace();
        do_reset();
        for (int i = 0; i < 8; i++) fill(20'(i + 16), 20'(i + 256), 1'b0, 1'b0);
        fill(20'h00100, 20'h00999, 1'b0, 1'b0);   // evicts entry 0 (page 16)
        fill(20'h00101, 20'h00998, 1'b0, 1'b0);   // evicts entry 1 (page 17)
        look("R6 evict0", {20'd16, 12'h0}, 1'b0, 32'h0, 1'b0);
        look("R6 evict1", {20'd17, 12'h0}, 1'b0, 32'h0, 1'b0);
        for (int i = 2; i < 8; i++)
            look("R6 keep", {20'(i + 16), 12'h004}, 1'b1, {20'(i + 256), 12'h004}, 1'b0);
        look("R6 new", 32'h0010_0000, 1'b1, 32'h0099_9000, 1'b0);
        // a freed slot is reused before the pointer is consulted
        @(negedge clk); inv_en = 1'b1; inv_vpn = 20'd20;   // entry 4
        @(negedge clk); inv_en = 1'b0;
        fill(20'h00200, 20'h00AAA, 1'b0, 1'b0);
        look("R6 free", {20'd18, 12'h0}, 1'b1, {20'd258, 12'h0}, 1'b0);
        look("R6 free", 32'h0020_0000, 1'b1, 32'h00AA_A000, 1'b0);
    endtask

    task automatic t_overwrite();
        do_reset();
        fill(20'h0A000, 20'h00001, 1'b0, 1'b0);   // entry 0
        fill(20'h0B000, 20'h00002, 1'b0, 1'b0);   // entry 1
        fill(20'h0A000, 20'h00003, 1'b0, 1'b1);   // rewrites entry 0
        look("R4 rewrite", 32'h0A00_0123, 1'b1, 32'h0000_3123, 1'b1);
        for (int i = 0; i < 6; i++) fill(20'(i + 32), 20'(i + 64), 1'b0, 1'b0);
        fill(20'h0C000, 20'h00004, 1'b0, 1'b0);   // full: pointer 0 evicts page 0A000
        look("R4 single slot", 32'h0A00_0000, 1'b0, 32'h0, 1'b0);
        look("R4 single slot", 32'h0B00_0000, 1'b1, 32'h0000_2000, 1'b0);
    endtask

    task automatic t_flush();
        do_reset();
        fill(20'h00010, 20'h00110, 1'b1, 1'b0);
        fill(20'h00020, 20'h00120, 1'b0, 1'b0);
        @(negedge clk); base_wr = 1'b1;
        @(negedge clk); base_wr = 1'b0;
        look("R7 global kept", 32'h0001_0004, 1'b1, 32'h0011_0004, 1'b0);
        look("R7 local dropped", 32'h0002_0004, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        fill(20'h00030, 20'h00130, 1'b0, 1'b0);
        @(negedge clk);
        base_wr = 1'b1;
        fill_en = 1'b1; fill_vpn = 20'h00040; fill_pfn = 20'h00140; fill_glb = 1'b0; fill_wr = 1'b1;
        @(negedge clk);
        base_wr = 1'b0; fill_en = 1'b0;
        look("R9 fill survives flush", 32'h0004_0000, 1'b1, 32'h0014_0000, 1'b1);
        look("R9 old dropped", 32'h0003_0000, 1'b0, 32'h0, 1'b0);
        @(negedge clk);
        inv_en = 1'b1; inv_vpn = 20'h00050;
        fill_en = 1'b1; fill_vpn = 20'h00050; fill_pfn = 20'h00150; fill_glb = 1'b0; fill_wr = 1'b0;
        @(negedge clk);
        inv_en = 1'b0; fill_en = 1'b0;
        look("R9 fill survives invalidate", 32'h0005_0000, 1'b1, 32'h0015_0000, 1'b0);
    endtask

    task automatic t_invalidate();
        do_reset();
        fill(20'h00060, 20'h00160, 1'b1, 1'b1);
        fill(20'h00070, 20'h00170, 1'b1, 1'b0);
        @(negedge clk); inv_en = 1'b1; inv_vpn = 20'h00060;
        @(negedge clk); inv_en = 1'b0;
        look("R8 global removed", 32'h0006_0000, 1'b0, 32'h0, 1'b0);
        look("R8 other kept", 32'h0007_0008, 1'b1, 32'h0017_0008, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_hit();
        t_fill_timing();
        t_alias();
        t_replace();
        t_overwrite();
        t_flush();
        t_same_cycle();
        t_invalidate();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule